// File: doc/BRIEF.md
# Two-Cycle Processor Bus Transfer Controller

This block turns single-word requests from a processor core into fixed-length transfers on an external bus with a 16-bit address, an 8-bit data path and separate active-low read and write strobes. A transfer always spans two clock cycles. The address goes out on the rising edge that opens the first cycle. The matching strobe goes low on the rising edge that opens the second cycle. A read captures the returned byte on the falling edge in the middle of the second cycle. A write drives its byte from the start of the second cycle and keeps driving it for half a cycle after the write strobe returns high. Memory latches on that rising strobe edge, so the byte is still valid when it does.

The bus data lines are modelled as an output byte with an output enable plus a separate input byte. An outer wrapper can join them into a tristate pad. On the core side, a request is offered with a valid flag while the controller reports that it is idle. The controller answers with a one-cycle done pulse, and read data is valid from that pulse onward. A new request offered in the done cycle starts on the very next rising edge. The reset input asserts asynchronously and its release is synchronised to the clock.

Top module: `bus2_ctrl`

## Requirements
- R1: A request accepted on rising edge E1 raises `req_done` for exactly one cycle, starting at rising edge E1+2. No other transfer completes in between.
- R2: `bus_addr` takes the request address on the accepting rising edge. It keeps that value until the next request is accepted.
- R3: For a read, `bus_rd_n` is low from rising edge E1+1 to rising edge E1+2, which is the second cycle, and low at no other time. `bus_oe` stays low throughout the read.
- R4: Read data is taken from `bus_din` on the falling edge in the middle of the second cycle. Values on `bus_din` at other times are not captured. `req_rdata` shows the captured byte from the done pulse until the next read capture, and write transfers leave it unchanged.
- R5: For a write, at rising edge E1+1 `bus_dout` takes the request data, `bus_oe` goes high and `bus_wr_n` goes low. `bus_wr_n` returns high at rising edge E1+2.
- R6: After the rising edge of `bus_wr_n`, `bus_oe` stays high and `bus_dout` stays unchanged until the next falling clock edge. Outside a write, `bus_oe` is low, including during reset.
- R7: `bus_rd_n` and `bus_wr_n` are never low together. Both are high whenever `req_ready` is high.
- R8: `req_ready` is high only when no transfer is in progress. Requests offered while it is low are ignored. A request offered while it is high is accepted on the next rising edge, including in the cycle of a done pulse.
- R9: Driving `rst_n` low at once forces both strobes high, `bus_oe` low, `req_done` low, and `bus_addr` and `req_rdata` to zero. After `rst_n` rises, requests are accepted from the third rising edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request byte address |
| req_wdata | input | 8 | Write byte |
| req_rdata | output | 8 | Last byte read |
| req_done | output | 1 | One-cycle completion pulse |
| bus_addr | output | 16 | Bus address |
| bus_dout | output | 8 | Byte driven onto the bus |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | 8 | Byte seen on the bus |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |

## Verification
The main function is exercised with reads and writes at the lowest, highest and mid-range addresses, with all-zero and all-one data bytes. Transfers are issued both after idle gaps and back to back, which separates a correct re-accept in the done cycle from an extra idle cycle. During reads the bus model puts valid data on `bus_din` only between the rising edge that opens cycle two and just after its falling edge, and drives a filler byte at all other times. A capture on any other edge therefore returns the filler. Garbage requests offered while the controller is busy must leave the address and data untouched. A reset in the middle of a write shows the asynchronous release of the strobes and the drive enable. The first accepted request after reset shows that release of reset takes two edges.

// File: rtl/bus2_pkg.sv
package bus2_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ONE  = 2'd1,
    PH_TWO  = 2'd2
  } phase_e;

endpackage

// File: rtl/bus2_rst_sync.sv
module bus2_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bus2_seq.sv
module bus2_seq
  import bus2_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output phase_e            phase,
  output logic              xfer_write,
  output logic [DATA_W-1:0] xfer_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              req_ready,
  output logic              req_done
);

  phase_e            phase_q, phase_d;
  logic              accept;
  logic              done_q, done_d;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    accept  = req_valid && (phase_q == PH_IDLE);
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (accept) phase_d = PH_ONE;
      PH_ONE:  phase_d = PH_TWO;
      PH_TWO:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
    done_d = (phase_q == PH_TWO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign phase      = phase_q;
  assign xfer_write = write_q;
  assign xfer_wdata = wdata_q;
  assign bus_addr   = addr_q;
  assign req_ready  = (phase_q == PH_IDLE);
  assign req_done   = done_q;

endmodule

// File: rtl/bus2_strobe.sv
module bus2_strobe
  import bus2_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              xfer_write,
  input  logic [DATA_W-1:0] xfer_wdata,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout
);

  logic              enter_two;
  logic              rd_n_q, rd_n_d;
  logic              wr_n_q, wr_n_d;
  logic              drive_q, drive_d;
  logic              trail_q;
  logic [DATA_W-1:0] dout_q;
  logic              dout_en;

  always_comb begin
    enter_two = (phase == PH_ONE);
    rd_n_d    = !(enter_two && !xfer_write);
    wr_n_d    = !(enter_two &&  xfer_write);
    drive_d   = enter_two && xfer_write;
    dout_en   = drive_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      drive_q <= 1'b0;
    end else begin
      rd_n_q  <= rd_n_d;
      wr_n_q  <= wr_n_d;
      drive_q <= drive_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_en) dout_q <= xfer_wdata;
  end

  // extends the drive half a cycle past the write strobe release
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) trail_q <= 1'b0;
    else        trail_q <= drive_q;
  end

  assign bus_rd_n = rd_n_q;
  assign bus_wr_n = wr_n_q;
  assign bus_oe   = drive_q | trail_q;
  assign bus_dout = dout_q;

endmodule

// File: rtl/bus2_rcap.sv
module bus2_rcap
  import bus2_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              xfer_write,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] req_rdata
);

  logic              cap_en;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    cap_en = (phase == PH_TWO) && !xfer_write;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= bus_din;
  end

  assign req_rdata = rdata_q;

endmodule

// File: rtl/bus2_ctrl.sv
module bus2_ctrl
  import bus2_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata,
  output logic              req_done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);

  logic              rst_sync_n;
  phase_e            phase;
  logic              xfer_write;
  logic [DATA_W-1:0] xfer_wdata;

  bus2_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bus2_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .phase      (phase),
    .xfer_write (xfer_write),
    .xfer_wdata (xfer_wdata),
    .bus_addr   (bus_addr),
    .req_ready  (req_ready),
    .req_done   (req_done)
  );

  bus2_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .phase      (phase),
    .xfer_write (xfer_write),
    .xfer_wdata (xfer_wdata),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_oe     (bus_oe),
    .bus_dout   (bus_dout)
  );

  bus2_rcap #(.DATA_W(DATA_W)) u_rcap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .phase      (phase),
    .xfer_write (xfer_write),
    .bus_din    (bus_din),
    .req_rdata  (req_rdata)
  );

endmodule

// File: rtl/bus2_ctrl_chk.sv
module bus2_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_oe,
  input logic              bus_rd_n,
  input logic              bus_wr_n
);

  // R7
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n || bus_wr_n);

  // R7
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_rd_n && bus_wr_n));

  // R3
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_oe);

  // R5
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_oe);

  // R3
  rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n) |=> $rose(bus_rd_n));

  // R5
  wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |=> $rose(bus_wr_n));

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  // R1
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> $past(!bus_rd_n || !bus_wr_n));

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> $stable(bus_addr));

  // R6
  wdata_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> (bus_oe && $stable(bus_dout)));

endmodule

bind bus2_ctrl bus2_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .req_done  (req_done),
  .bus_addr  (bus_addr),
  .bus_dout  (bus_dout),
  .bus_oe    (bus_oe),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n)
);

// File: tb/bus2_ctrl_bench.sv
module bus2_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [7:0] FILL = 8'hEE;

  // {write, address, data}; for reads the data column is unused
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 16'h0005, 8'h00},
    {1'b1, 16'h0009, 8'hA5},
    {1'b0, 16'hFFFF, 8'h00},
    {1'b1, 16'hFFFF, 8'h3C},
    {1'b0, 16'h8000, 8'h00},
    {1'b1, 16'h0000, 8'hFF},
    {1'b1, 16'h1234, 8'h00},
    {1'b0, 16'h00FF, 8'h00}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  req_rdata;
  logic        req_done;
  logic [15:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_oe;
  logic [7:0]  bus_din;
  logic        bus_rd_n;
  logic        bus_wr_n;

  int n_checks;
  int n_fail;
  int lw_cnt;
  logic [15:0] lw_addr;
  logic [7:0]  lw_data;
  logic        lw_oe;
  logic [7:0]  last_rd;

  bus2_ctrl u_bus2_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_rdata (req_rdata),
    .req_done  (req_done),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe),
    .bus_din   (bus_din),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model: valid read byte only from just after the rising edge
  // that opens cycle two until just after the falling edge in its middle
  always begin
    @(posedge clk);
    #1;
    if (!bus_rd_n) bus_din = mem_byte(bus_addr);
    else           bus_din = FILL;
    @(negedge clk);
    #1;
    bus_din = FILL;
  end

  // memory latches on the inactive write strobe transition
  always @(posedge bus_wr_n) begin
    lw_cnt  = lw_cnt + 1;
    lw_addr = bus_addr;
    lw_data = bus_dout;
    lw_oe   = bus_oe;
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // called 2 time units after a rising edge with the controller idle
  task automatic do_xfer(input logic wr, input logic [15:0] a, input logic [7:0] d);
    int cnt0;
    cnt0 = lw_cnt;
    check(req_ready == 1'b1, "R8 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    step();  // E1: accepted
    check(bus_addr == a, "R2 address at accept", bus_addr, a);
    check(bus_rd_n && bus_wr_n, "R7 strobes high in cycle one", {bus_rd_n, bus_wr_n}, 2'b11);
    check(req_ready == 1'b0, "R8 busy in cycle one", req_ready, 0);
    check(req_done == 1'b0, "R1 no done in cycle one", req_done, 0);
    req_write = ~wr;
    req_addr  = ~a;
    req_wdata = ~d;
    step();  // E2: cycle two
    req_valid = 1'b0;
    check(bus_addr == a, "R8 busy request ignored", bus_addr, a);
    if (wr) begin
      check(!bus_wr_n && bus_rd_n, "R5 write strobe low", {bus_rd_n, bus_wr_n}, 2'b10);
      check(bus_oe == 1'b1, "R5 drive enable", bus_oe, 1);
      check(bus_dout == d, "R5 write byte", bus_dout, d);
    end else begin
      check(!bus_rd_n && bus_wr_n, "R3 read strobe low", {bus_rd_n, bus_wr_n}, 2'b01);
      check(bus_oe == 1'b0, "R3 no drive on read", bus_oe, 0);
    end
    step();  // E3: done
    check(bus_rd_n && bus_wr_n, "R7 strobes released", {bus_rd_n, bus_wr_n}, 2'b11);
    check(req_done == 1'b1, "R1 done two cycles after accept", req_done, 1);
    check(req_ready == 1'b1, "R8 ready with done", req_ready, 1);
    check(bus_addr == a, "R2 address held", bus_addr, a);
    if (wr) begin
      check(bus_oe == 1'b1, "R6 drive held past strobe", bus_oe, 1);
      check(bus_dout == d, "R6 byte held past strobe", bus_dout, d);
      check(lw_cnt == cnt0 + 1, "R5 one strobe release", lw_cnt, cnt0 + 1);
      check(lw_addr == a, "R5 latched address", lw_addr, a);
      check(lw_data == d, "R6 latched byte", lw_data, d);
      check(lw_oe == 1'b1, "R6 driven at latch", lw_oe, 1);
      check(req_rdata == last_rd, "R4 write leaves read data", req_rdata, last_rd);
    end else begin
      check(req_rdata == mem_byte(a), "R4 read byte", req_rdata, mem_byte(a));
      last_rd = mem_byte(a);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 3000);
    n_fail   = n_fail + 1;
    n_checks = n_checks + 1;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    n_checks  = 0;
    n_fail    = 0;
    lw_cnt    = 0;
    lw_addr   = '0;
    lw_data   = '0;
    lw_oe     = 1'b0;
    last_rd   = 8'h00;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    bus_din   = FILL;

    step();
    step();
    // R9 reset state
    check(bus_rd_n && bus_wr_n, "R9 strobes high in reset", {bus_rd_n, bus_wr_n}, 2'b11);
    check(bus_oe == 1'b0, "R6 no drive in reset", bus_oe, 0);
    check(req_done == 1'b0, "R9 no done in reset", req_done, 0);
    check(bus_addr == 16'h0, "R9 address cleared", bus_addr, 0);
    check(req_rdata == 8'h0, "R9 read data cleared", req_rdata, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step();

    // idle: nothing moves
    for (int k = 0; k < 3; k++) begin
      step();
      check(bus_rd_n && bus_wr_n && !bus_oe && !req_done && req_ready,
            "R7 idle bus quiet", {bus_rd_n, bus_wr_n, bus_oe, req_done, req_ready}, 5'b11001);
    end

    // table walk: even entries follow an idle gap, odd ones run back to back
    for (int i = 0; i < NVEC; i++) begin
      do_xfer(VEC[i][24], VEC[i][23:8], VEC[i][7:0]);
      if (i % 2 == 1) begin
        step();
        check(req_done == 1'b0, "R1 done lasts one cycle", req_done, 0);
        check(bus_oe == 1'b0, "R6 drive off after hold", bus_oe, 0);
        check(bus_rd_n && bus_wr_n, "R7 strobes high after transfer", {bus_rd_n, bus_wr_n}, 2'b11);
      end
    end

    // reset in the middle of a write
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = 16'h2468;
    req_wdata = 8'h81;
    step();
    req_valid = 1'b0;
    step();
    check(!bus_wr_n && bus_oe, "R5 write under way", {bus_wr_n, bus_oe}, 2'b01);
    rst_n = 1'b0;
    #1;
    check(bus_wr_n && bus_rd_n, "R9 strobes forced high", {bus_rd_n, bus_wr_n}, 2'b11);
    check(bus_oe == 1'b0, "R6 drive dropped in reset", bus_oe, 0);
    check(bus_addr == 16'h0, "R9 address forced clear", bus_addr, 0);
    step();
    step();
    rst_n     = 1'b1;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 16'h4321;
    step();
    check(bus_addr == 16'h0, "R9 no accept on first edge", bus_addr, 0);
    step();
    check(bus_addr == 16'h0, "R9 no accept on second edge", bus_addr, 0);
    do_xfer(1'b0, 16'h4321, 8'h00);
    step();
    check(req_done == 1'b0, "R1 done drops after reset transfer", req_done, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule